// File: doc/BRIEF.md
# Satellite Tone Mode Controller

This block produces the digital gating signal for the 22 kHz control tone of a satellite low-noise-block supply, together with a flag that says when the tone is being sent. Two register bits select the behaviour. The first is the tone enable and the second is the external select. A single asynchronous logic input is interpreted according to those bits. The analog stage after this block sets the amplitude and the edge rates of the tone; this block decides only when the tone is present and what waveform it follows.

With the external select clear, the input acts as an envelope. While the input is high, an internal divider drives a square wave at the tone frequency. The divider restarts on every envelope rise, so each burst begins with a complete high half-period. Holding the input high gives a continuous tone. With the external select set, the input already carries a tone waveform, and that waveform is passed to the output. Output starts about 1 µs after the first edge is seen on the input. It stops about 60 µs after the last edge. Clearing the enable bit silences everything.

Clock frequency, tone frequency, start delay, hold time and synchronizer depth are all parameters. The cycle counts are derived from them when the block is elaborated.

Top module: `tone_mode_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until a stimulus arrives, `tone_out` and `tone_active` are 0.
- R2: When `tone_en` is 0 at a clock edge, `tone_out` and `tone_active` are 0 after that edge, whatever the values of `tone_in` and `ext_mode`.
- R3: Envelope mode (`tone_en`=1, `ext_mode`=0): `tone_active` rises exactly 3 clock edges after `tone_in` rises and falls exactly 3 edges after `tone_in` falls.
- R4: In envelope mode, `tone_out` is a square wave with a period of 2*HALF_CYC clocks and 50% duty, where HALF_CYC = CLK_HZ/(2*TONE_HZ). Its first half-period is high, lasts a full HALF_CYC clocks, and begins on the same edge as `tone_active`.
- R5: With `tone_en`=1, `ext_mode`=0 and `tone_in` held high, the tone continues without a break for as long as the input stays high.
- R6: External mode (`tone_en`=1, `ext_mode`=1): `tone_active` rises exactly START_CYC+4 clock edges after the first input edge, where START_CYC = CLK_HZ*START_NS/1e9. It is 0 before then.
- R7: In external mode, while `tone_active` is 1, `tone_out` equals `tone_in` delayed by 3 clock edges. `tone_out` is never 1 while `tone_active` is 0.
- R8: In external mode, gaps between input edges shorter than HOLD_CYC = CLK_HZ*HOLD_NS/1e9 keep the tone active. `tone_active` and `tone_out` drop exactly HOLD_CYC+4 edges after the last input edge, even if the input stays high.
- R9: A change of either control bit takes effect on the next edge and cancels any pending start delay or hold time. A later return to external mode does not start the tone until a new input edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| tone_en | input | 1 | Tone enable register bit |
| ext_mode | input | 1 | 1: input carries the tone; 0: input is an envelope |
| tone_in | input | 1 | Asynchronous logic input (tone or envelope) |
| tone_out | output | 1 | Gated tone waveform to the analog stage |
| tone_active | output | 1 | 1 while the tone is being sent |

## Verification
The bench measures the envelope response to the exact edge. A divider that keeps running freely between bursts, or that starts on a low phase, gives a short or inverted first half-period, and the bench catches this at randomly placed sample points in bursts of random length. In external mode the bench checks one edge before and one edge after the start boundary and the hold boundary, so an off-by-one timer, or a hold counter that is not reloaded by each edge, changes a sampled value. The last corner cases are control changes: one made in the middle of the start delay, and one made while the tone is active followed by a return to external mode with a quiet input. A design that keeps its timers through such a change restarts the tone when it should not.

// File: rtl/tone_pkg.sv
package tone_pkg;

   typedef enum logic [1:0] {
      TRK_IDLE = 2'd0,
      TRK_ARM  = 2'd1,
      TRK_ON   = 2'd2
   } trk_state_t;

   // whole clock cycles in a span of ns nanoseconds
   function automatic int unsigned ns_to_cycles(input longint unsigned clk_hz,
                                                input longint unsigned ns);
      longint unsigned prod;
      prod = clk_hz * ns;
      return 32'(prod / 64'd1_000_000_000);
   endfunction

   // clock cycles in one half period of the tone
   function automatic int unsigned half_period_cycles(input longint unsigned clk_hz,
                                                      input longint unsigned tone_hz);
      return 32'(clk_hz / (64'd2 * tone_hz));
   endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_q,
   output logic edge_p
);

   logic [STAGES-1:0] chain;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("tone_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= '0;
         last_q <= 1'b0;
      end else begin
         chain  <= {chain[STAGES-2:0], async_in};
         last_q <= chain[STAGES-1];
      end
   end

   assign sync_q = chain[STAGES-1];
   assign edge_p = sync_q ^ last_q;

   // R6
   edge_is_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_p |-> (sync_q != $past(sync_q)));

endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
   parameter int unsigned HALF_CYC = 4545
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sq
);

   localparam int unsigned CW = $clog2(HALF_CYC + 1);

   logic [CW-1:0] cnt;

   if (HALF_CYC < 2) begin : g_bad_half
      $error("tone_divider: HALF_CYC must be at least 2");
   end

   // while idle, park at the start of a high half-period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sq  <= 1'b1;
      end else if (!run) begin
         cnt <= '0;
         sq  <= 1'b1;
      end else if (cnt == CW'(HALF_CYC - 1)) begin
         cnt <= '0;
         sq  <= ~sq;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R4
   half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt != CW'(HALF_CYC - 1)) |=> $stable(sq));

   // R4
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run) |=> (sq && cnt == '0));

endmodule

// File: rtl/tone_ext_tracker.sv
module tone_ext_tracker
   import tone_pkg::*;
#(
   parameter int unsigned START_CYC = 200,
   parameter int unsigned HOLD_CYC  = 12000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic clear,
   input  logic edge_i,
   output logic on
);

   localparam int unsigned SCW = $clog2(START_CYC + 1);
   localparam int unsigned HCW = $clog2(HOLD_CYC + 1);

   trk_state_t     state;
   logic [SCW-1:0] start_cnt;
   logic [HCW-1:0] hold_cnt;

   if (START_CYC < 1 || START_CYC >= HOLD_CYC) begin : g_bad_timing
      $error("tone_ext_tracker: need 1 <= START_CYC < HOLD_CYC");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= TRK_IDLE;
         start_cnt <= '0;
         hold_cnt  <= '0;
      end else if (clear || !enable) begin
         state     <= TRK_IDLE;
         start_cnt <= '0;
         hold_cnt  <= '0;
      end else begin
         // cycles since the most recent edge, saturating
         if (edge_i) begin
            hold_cnt <= '0;
         end else if (hold_cnt != HCW'(HOLD_CYC - 1)) begin
            hold_cnt <= hold_cnt + 1'b1;
         end
         unique case (state)
            TRK_IDLE: begin
               if (edge_i) begin
                  state     <= TRK_ARM;
                  start_cnt <= '0;
               end
            end
            TRK_ARM: begin
               if (start_cnt == SCW'(START_CYC - 1)) begin
                  state <= TRK_ON;
               end else begin
                  start_cnt <= start_cnt + 1'b1;
               end
            end
            TRK_ON: begin
               if (!edge_i && hold_cnt == HCW'(HOLD_CYC - 1)) begin
                  state <= TRK_IDLE;
               end
            end
            default: state <= TRK_IDLE;
         endcase
      end
   end

   assign on = (state == TRK_ON);

   // R6
   no_skip_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TRK_IDLE) |=> (state != TRK_ON));

   // R9
   clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (state == TRK_IDLE));

   // R8
   edge_keeps_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TRK_ON && edge_i && enable && !clear) |=> (state == TRK_ON));

endmodule

// File: rtl/tone_mode_ctrl.sv
module tone_mode_ctrl
   import tone_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 200_000_000,
   parameter int unsigned TONE_HZ     = 22_000,
   parameter int unsigned START_NS    = 1_000,
   parameter int unsigned HOLD_NS     = 60_000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tone_en,
   input  logic ext_mode,
   input  logic tone_in,
   output logic tone_out,
   output logic tone_active
);

   localparam int unsigned HALF_CYC  = half_period_cycles(64'(CLK_HZ), 64'(TONE_HZ));
   localparam int unsigned START_CYC = ns_to_cycles(64'(CLK_HZ), 64'(START_NS));
   localparam int unsigned HOLD_CYC  = ns_to_cycles(64'(CLK_HZ), 64'(HOLD_NS));

   if (TONE_HZ == 0 || CLK_HZ < 4 * TONE_HZ) begin : g_bad_clock
      $error("tone_mode_ctrl: clock too slow for the tone frequency");
   end

   logic       in_sync;
   logic       in_edge;
   logic       div_sq;
   logic       trk_on;
   logic [1:0] ctrl_q;
   logic       ctrl_chg;
   logic       ext_sel;
   logic       env_sel;
   logic       env_run;

   assign ext_sel  = tone_en & ext_mode;
   assign env_sel  = tone_en & ~ext_mode;
   assign ctrl_chg = (ctrl_q != {tone_en, ext_mode});
   assign env_run  = env_sel & in_sync;

   tone_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (tone_in),
      .sync_q   (in_sync),
      .edge_p   (in_edge)
   );

   tone_divider #(
      .HALF_CYC (HALF_CYC)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (env_run),
      .sq    (div_sq)
   );

   tone_ext_tracker #(
      .START_CYC (START_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (ext_sel),
      .clear  (ctrl_chg),
      .edge_i (in_edge),
      .on     (trk_on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= 2'b00;
         tone_out    <= 1'b0;
         tone_active <= 1'b0;
      end else begin
         ctrl_q      <= {tone_en, ext_mode};
         tone_out    <= env_run ? div_sq : (ext_sel & trk_on & in_sync);
         tone_active <= env_run | (ext_sel & trk_on);
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      (!rst_n) |=> (!tone_out && !tone_active));

   // R2
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tone_en) |=> (!tone_out && !tone_active));

   // R7
   out_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tone_out |-> tone_active);

   // R3
   env_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (env_sel && $rose(in_sync)) |=> (tone_active && tone_out));

endmodule

// File: tb/tb_tone_mode_ctrl.sv
module tb_tone_mode_ctrl;

   localparam int unsigned CLK_HZ_TB = 200_000_000;
   localparam int HALF  = CLK_HZ_TB / (2 * 22_000);
   localparam int START = CLK_HZ_TB / 1_000_000;
   localparam int HOLD  = (CLK_HZ_TB / 1_000_000) * 60;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tone_en = 1'b0;
   logic ext_mode = 1'b0;
   logic tone_in = 1'b0;
   logic tone_out;
   logic tone_active;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tone_mode_ctrl #(
      .CLK_HZ      (CLK_HZ_TB),
      .TONE_HZ     (22_000),
      .START_NS    (1_000),
      .HOLD_NS     (60_000),
      .SYNC_STAGES (2)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tone_en     (tone_en),
      .ext_mode    (ext_mode),
      .tone_in     (tone_in),
      .tone_out    (tone_out),
      .tone_active (tone_active)
   );

   // expected envelope tone n edges after the input rose
   function automatic logic env_expect(input int n);
      if (n < 3) return 1'b0;
      return (((n - 3) / HALF) % 2) == 0;
   endfunction

   task automatic adv(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (190_000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int r;
      r = $urandom(32'd4242);

      // R1 reset state
      adv(5);
      check("R1 reset out", tone_out, 1'b0);
      check("R1 reset active", tone_active, 1'b0);
      rst_n = 1'b1;
      adv(4);
      check("R1 after release out", tone_out, 1'b0);
      check("R1 after release active", tone_active, 1'b0);

      // R2 disabled, random input and mode
      for (int i = 0; i < 6; i++) begin
         ext_mode = 1'($urandom_range(0, 1));
         tone_in  = ~tone_in;
         adv($urandom_range(5, 300));
         check("R2 disabled out", tone_out, 1'b0);
         check("R2 disabled active", tone_active, 1'b0);
      end
      tone_in  = 1'b0;
      ext_mode = 1'b0;
      adv(10);

      // R3/R4 directed envelope burst
      tone_en = 1'b1;
      adv(10);
      tone_in = 1'b1;
      adv(2);
      check("R3 active before 3 edges", tone_active, 1'b0);
      adv(1);
      check("R3 active at 3 edges", tone_active, 1'b1);
      check("R4 first half high", tone_out, 1'b1);
      adv(HALF - 1);
      check("R4 last high cycle", tone_out, 1'b1);
      adv(1);
      check("R4 first low cycle", tone_out, 1'b0);
      adv(HALF - 1);
      check("R4 last low cycle", tone_out, 1'b0);
      adv(1);
      check("R4 second period high", tone_out, 1'b1);
      tone_in = 1'b0;
      adv(2);
      check("R3 active held 2 edges", tone_active, 1'b1);
      adv(1);
      check("R3 active fall", tone_active, 1'b0);
      check("R3 out fall", tone_out, 1'b0);

      // R4 random envelope bursts, divider restarts each time
      for (int it = 0; it < 3; it++) begin
         int len;
         int pos;
         adv($urandom_range(20, 400));
         tone_in = 1'b1;
         len = $urandom_range(HALF / 2, 2 * HALF + HALF / 2);
         pos = 0;
         for (int j = 0; j < 4; j++) begin
            int tgt;
            tgt = 3 + ((len - 1) * j) / 3;
            adv(tgt - pos);
            pos = tgt;
            check("R4 random burst tone", tone_out, env_expect(tgt));
            check("R3 random burst active", tone_active, 1'b1);
         end
         tone_in = 1'b0;
         adv(3);
         check("R3 burst end active", tone_active, 1'b0);
      end

      // R5 continuous tone
      adv(50);
      tone_in = 1'b1;
      adv(3 + HALF / 2);
      check("R5 continuous j0", tone_out, 1'b1);
      for (int j = 1; j < 4; j++) begin
         adv(HALF);
         check("R5 continuous", tone_out, (j % 2) == 0);
         check("R5 continuous active", tone_active, 1'b1);
      end
      tone_in = 1'b0;
      adv(10);

      // R6 external start delay
      ext_mode = 1'b1;
      adv(10);
      check("R6 idle before edge", tone_active, 1'b0);
      tone_in = 1'b1;
      adv(START + 3);
      check("R6 not yet active", tone_active, 1'b0);
      adv(1);
      check("R6 active on time", tone_active, 1'b1);
      check("R7 out follows high", tone_out, 1'b1);

      // R7 pass-through of a random external waveform
      adv(1000);
      for (int i = 0; i < 5; i++) begin
         int h;
         h = $urandom_range(1500, 5000);
         tone_in = ~tone_in;
         adv(h / 2);
         check("R7 pass-through", tone_out, tone_in);
         check("R8 gap keeps active", tone_active, 1'b1);
         adv(h - h / 2);
      end

      // R8 hold after last edge, input left high
      tone_in = 1'b1;
      adv(HOLD + 3);
      check("R8 still held", tone_active, 1'b1);
      check("R8 still passing", tone_out, 1'b1);
      adv(1);
      check("R8 released active", tone_active, 1'b0);
      check("R8 released out", tone_out, 1'b0);

      // R9 mode change while active
      tone_in = 1'b0;
      adv(START + 10);
      check("R6 restart active", tone_active, 1'b1);
      ext_mode = 1'b0;
      adv(1);
      check("R9 change to envelope", tone_active, 1'b0);
      ext_mode = 1'b1;
      adv(START + 10);
      check("R9 no restart without edge", tone_active, 1'b0);

      // R9 change during the start delay
      tone_in = 1'b1;
      adv(START / 2);
      check("R6 arming", tone_active, 1'b0);
      tone_en = 1'b0;
      adv(1);
      check("R2 disabled mid-arm", tone_active, 1'b0);
      tone_en = 1'b1;
      adv(START + 10);
      check("R9 start cancelled", tone_active, 1'b0);
      tone_in = 1'b0;
      adv(START + 4);
      check("R6 recover after cancel", tone_active, 1'b1);

      // R2 disable while active
      tone_en = 1'b0;
      adv(1);
      check("R2 disable active", tone_active, 1'b0);
      check("R2 disable out", tone_out, 1'b0);
      for (int i = 0; i < 2; i++) begin
         tone_in = ~tone_in;
         adv(50);
         check("R2 disabled toggles", tone_active | tone_out, 1'b0);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule